// File: doc/BRIEF.md
# Coprocessor Host Register Bank

This block is the host-facing register file of a small 16-bit interrupt coprocessor. A host reaches it over a 16-bit bus that has a request strobe, a write flag, a word offset and one select per byte lane. The bank keeps the storage the host sees: a master control word, the vector base, a software trigger word, a semaphore word, a 4-bit condition code, the program counter, seven general registers and a read-only bank of eight interrupt flag words. The block also drives the control bits directly to the core.

Several registers use a masked write format. The high byte of the write carries one enable bit for each bit of the low byte, so the host can set or clear single bits without reading first. Such a write must select both byte lanes. The vector base is locked against writes while the core is enabled. Instruction execution, the arbitration of semaphores and the interrupt channel logic are outside this block.

Word offsets: 0 control, 1 vector base, 2 trigger, 3 semaphore, 4 condition code, 5 program counter, 6 to 12 general registers R1 to R7, 16 to 23 flag words 0 to 7. Every other offset is unmapped.

Top module: `hrb_host_regs`

## Requirements
- R1: After reset, every register reads 0, except the vector base, which reads 0xFE00, and flag word 0, which reads 0x0001.
- R2: A request sampled at a clock edge gives ack_o high for the following cycle. A read returns its data in rdata_o in that same cycle. ack_o is low in the cycle after any edge at which no request was sampled.
- R3: Control word (offset 0) layout: bit 7 enable, bit 6 freeze, bit 5 debug, bit 4 force-active, bit 2 single-step, bit 1 software error flag, bit 0 interrupt enable. Bit 3 reads 0. A write applies only when both lanes are selected. Low-byte bit n then takes its new value only if bit n+8 of the write data is 1; otherwise it keeps its value.
- R4: A control write with both lanes, mask bit 10 and value bit 2 makes core_step_o high for exactly the cycle after the write edge. Bit 2 always reads back 0.
- R5: The vector base (offset 1) takes byte-lane writes, each selected lane updating only its own byte. Bit 0 always reads 0.
- R6: While the control enable bit is 1, any write to the vector base leaves it unchanged.
- R7: The trigger (offset 2) and semaphore (offset 3) registers each hold 8 bits in the masked format of R3. A write with only one lane selected has no effect. A word write of 0xFFFF reads 0x00FF, and a word write of 0xFF00 clears all bits.
- R8: The condition code (offset 4) holds 4 bits. A low-lane write loads data bits 3:0. The high lane has no effect.
- R9: The program counter and R1 to R7 are 16-bit registers with independent high-lane and low-lane writes.
- R10: The flag words (offsets 16 to 23) are read-only. Writes to them leave the values that reads return unchanged.
- R11: Unmapped offsets read 0, and writes to them change no register.
- R12: The outputs core_enable_o, core_freeze_o, core_debug_o, core_force_o, core_swerr_o and core_irqen_o show the stored control bits. vbase_o shows the vector base as it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 5 | Word offset |
| be_i | input | 2 | Byte-lane selects (bit 0 = low byte) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| ack_o | output | 1 | One-cycle acknowledge |
| core_enable_o | output | 1 | Core enable |
| core_freeze_o | output | 1 | Core freeze |
| core_debug_o | output | 1 | Debug mode |
| core_force_o | output | 1 | Force-active |
| core_step_o | output | 1 | Single-step pulse |
| core_swerr_o | output | 1 | Software error flag |
| core_irqen_o | output | 1 | Interrupt enable |
| vbase_o | output | 16 | Vector base |

## Verification
The bound checker watches, on every cycle, the acknowledge timing and the zero read data of unmapped offsets. It also checks that the control outputs hold across any cycle without a full-lane control write, that the vector base holds under the enable lock and keeps bit 0 clear, and that every step pulse comes from a control write. The bench scenarios cover the value rules: the masked updates, the lane splits of the plain registers, the condition code width, the read-only flag bank and the reset image. The bench compares these against a bench model under random traffic and under directed sequences.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

   // word offsets of the fixed registers
   localparam int unsigned OFS_CTL   = 0;
   localparam int unsigned OFS_VBASE = 1;
   localparam int unsigned OFS_TRIG  = 2;
   localparam int unsigned OFS_SEM   = 3;
   localparam int unsigned OFS_CCR   = 4;
   localparam int unsigned OFS_PC    = 5;
   localparam int unsigned OFS_GPR0  = 6;

   // control word bit positions (mask for bit n lives at n + half width)
   localparam int unsigned CB_IRQEN  = 0;
   localparam int unsigned CB_SWERR  = 1;
   localparam int unsigned CB_STEP   = 2;
   localparam int unsigned CB_FORCE  = 4;
   localparam int unsigned CB_DEBUG  = 5;
   localparam int unsigned CB_FREEZE = 6;
   localparam int unsigned CB_ENABLE = 7;

   // which control bits keep state (step is a pulse, bit 3 is spare)
   localparam logic [7:0] CTL_KEEP = 8'b1111_0011;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_CTL,
      SEL_VBASE,
      SEL_TRIG,
      SEL_SEM,
      SEL_CCR,
      SEL_PC,
      SEL_GPR,
      SEL_FLAG
   } rd_sel_e;

endpackage

// File: rtl/hrb_decode.sv
module hrb_decode
   import hrb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned NUM_GPR    = 7,
   parameter int unsigned FLAG_BASE  = 16,
   parameter int unsigned FLAG_WORDS = 8,
   localparam int unsigned IDX_N     = (NUM_GPR > FLAG_WORDS) ? NUM_GPR : FLAG_WORDS,
   localparam int unsigned IDX_W     = (IDX_N > 1) ? $clog2(IDX_N) : 1
) (
   input  logic [ADDR_W-1:0] adr_i,
   output rd_sel_e           sel_o,
   output logic [IDX_W-1:0]  idx_o
);

   if (OFS_GPR0 + NUM_GPR > FLAG_BASE) begin : g_bad_gpr
      $error("general registers overlap the flag bank");
   end
   if (FLAG_BASE + FLAG_WORDS > (1 << ADDR_W)) begin : g_bad_flag
      $error("flag bank does not fit the offset space");
   end

   always_comb begin
      int a;
      a     = int'(adr_i);
      sel_o = SEL_NONE;
      idx_o = '0;
      if (a == int'(OFS_CTL))        sel_o = SEL_CTL;
      else if (a == int'(OFS_VBASE)) sel_o = SEL_VBASE;
      else if (a == int'(OFS_TRIG))  sel_o = SEL_TRIG;
      else if (a == int'(OFS_SEM))   sel_o = SEL_SEM;
      else if (a == int'(OFS_CCR))   sel_o = SEL_CCR;
      else if (a == int'(OFS_PC))    sel_o = SEL_PC;
      else if (a >= int'(OFS_GPR0) && a < int'(OFS_GPR0 + NUM_GPR)) begin
         sel_o = SEL_GPR;
         idx_o = IDX_W'(a - int'(OFS_GPR0));
      end
      else if (a >= int'(FLAG_BASE) && a < int'(FLAG_BASE + FLAG_WORDS)) begin
         sel_o = SEL_FLAG;
         idx_o = IDX_W'(a - int'(FLAG_BASE));
      end
   end

endmodule

// File: rtl/hrb_mask_reg.sv
// Register in masked format: high half of the write word enables the
// matching low-half bit. Applies only when every byte lane is selected.
module hrb_mask_reg #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned VAL_W = DATA_W / 2,
   localparam int unsigned BE_W  = DATA_W / 8,
   parameter logic [VAL_W-1:0] KEEP  = '1,
   parameter logic [VAL_W-1:0] RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [VAL_W-1:0]  q_o
);

   if (DATA_W % 16 != 0) begin : g_bad_width
      $error("masked register needs a width that is a multiple of 16");
   end

   logic [VAL_W-1:0] q_r;
   logic [VAL_W-1:0] nxt;

   always_comb begin
      nxt = q_r;
      if (wr_en_i && (&be_i)) begin
         for (int i = 0; i < int'(VAL_W); i++) begin
            if (wdata_i[VAL_W + i]) nxt[i] = wdata_i[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RESET & KEEP;
      else        q_r <= nxt & KEEP;
   end

   assign q_o = q_r;

endmodule

// File: rtl/hrb_lane_reg.sv
// Register with independent byte-lane writes; bits outside IMPL read 0.
module hrb_lane_reg #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned BE_W  = DATA_W / 8,
   parameter logic [DATA_W-1:0] IMPL  = '1,
   parameter logic [DATA_W-1:0] RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] q_o
);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("lane register needs whole bytes");
   end

   for (genvar l = 0; l < int'(BE_W); l++) begin : g_lane
      if (IMPL[l*8 +: 8] == 8'h00) begin : g_empty
         assign q_o[l*8 +: 8] = 8'h00;
      end else begin : g_store
         logic [7:0] lq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   lq <= RESET[l*8 +: 8];
            else if (wr_en_i && be_i[l])  lq <= wdata_i[l*8 +: 8];
         end
         assign q_o[l*8 +: 8] = lq & IMPL[l*8 +: 8];
      end
   end

endmodule

// File: rtl/hrb_rd_mux.sv
module hrb_rd_mux
   import hrb_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_GPR    = 7,
   parameter int unsigned FLAG_WORDS = 8,
   localparam int unsigned VAL_W     = DATA_W / 2,
   localparam int unsigned IDX_N     = (NUM_GPR > FLAG_WORDS) ? NUM_GPR : FLAG_WORDS,
   localparam int unsigned IDX_W     = (IDX_N > 1) ? $clog2(IDX_N) : 1
) (
   input  rd_sel_e           sel_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [VAL_W-1:0]  ctl_i,
   input  logic [DATA_W-1:0] vbase_i,
   input  logic [VAL_W-1:0]  trig_i,
   input  logic [VAL_W-1:0]  sem_i,
   input  logic [DATA_W-1:0] ccr_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] gpr_i  [NUM_GPR],
   input  logic [DATA_W-1:0] flag_i [FLAG_WORDS],
   output logic [DATA_W-1:0] data_o
);

   always_comb begin
      unique case (sel_i)
         SEL_CTL:   data_o = DATA_W'(ctl_i);
         SEL_VBASE: data_o = vbase_i;
         SEL_TRIG:  data_o = DATA_W'(trig_i);
         SEL_SEM:   data_o = DATA_W'(sem_i);
         SEL_CCR:   data_o = ccr_i;
         SEL_PC:    data_o = pc_i;
         SEL_GPR:   data_o = gpr_i[idx_i];
         SEL_FLAG:  data_o = flag_i[idx_i];
         default:   data_o = '0;
      endcase
   end

endmodule

// File: rtl/hrb_host_regs.sv
module hrb_host_regs
   import hrb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_GPR     = 7,
   parameter int unsigned FLAG_BASE   = 16,
   parameter int unsigned FLAG_WORDS  = 8,
   parameter int unsigned CCR_BITS    = 4,
   parameter logic [15:0] VBASE_RESET = 16'hFE00,
   parameter logic [15:0] FLAG0_RESET = 16'h0001
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic                  we_i,
   input  logic [ADDR_W-1:0]     adr_i,
   input  logic [DATA_W/8-1:0]   be_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  ack_o,
   output logic                  core_enable_o,
   output logic                  core_freeze_o,
   output logic                  core_debug_o,
   output logic                  core_force_o,
   output logic                  core_step_o,
   output logic                  core_swerr_o,
   output logic                  core_irqen_o,
   output logic [DATA_W-1:0]     vbase_o
);

   localparam int unsigned HALF  = DATA_W / 2;
   localparam int unsigned BE_W  = DATA_W / 8;
   localparam int unsigned IDX_N = (NUM_GPR > FLAG_WORDS) ? NUM_GPR : FLAG_WORDS;
   localparam int unsigned IDX_W = (IDX_N > 1) ? $clog2(IDX_N) : 1;
   localparam logic [DATA_W-1:0] VB_IMPL  = ~DATA_W'(1);
   localparam logic [DATA_W-1:0] CCR_IMPL = DATA_W'((1 << CCR_BITS) - 1);
   localparam logic [HALF-1:0]   CTL_IMPL = HALF'(CTL_KEEP);

   if (DATA_W % 16 != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of 16");
   end
   if (CCR_BITS < 1 || CCR_BITS > 8) begin : g_bad_ccr
      $error("CCR_BITS must be 1..8");
   end
   if (NUM_GPR < 1 || FLAG_WORDS < 1) begin : g_bad_cnt
      $error("register counts must be positive");
   end

   rd_sel_e          sel;
   logic [IDX_W-1:0] idx;
   logic             wr;
   logic             all_lanes;

   hrb_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_GPR   (NUM_GPR),
      .FLAG_BASE (FLAG_BASE),
      .FLAG_WORDS(FLAG_WORDS)
   ) u_decode (
      .adr_i (adr_i),
      .sel_o (sel),
      .idx_o (idx)
   );

   assign wr        = req_i & we_i;
   assign all_lanes = &be_i;

   // ---------------- control word ----------------
   logic [HALF-1:0] ctl_q;
   logic            step_q;

   hrb_mask_reg #(
      .DATA_W(DATA_W),
      .KEEP  (CTL_IMPL),
      .RESET ('0)
   ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && sel == SEL_CTL),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .q_o    (ctl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= wr && sel == SEL_CTL && all_lanes &&
                            wdata_i[HALF + CB_STEP] && wdata_i[CB_STEP];
   end

   // ---------------- vector base (locked while enabled) ----------------
   logic [DATA_W-1:0] vbase_q;

   hrb_lane_reg #(
      .DATA_W(DATA_W),
      .IMPL  (VB_IMPL),
      .RESET (DATA_W'(VBASE_RESET))
   ) u_vbase (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && sel == SEL_VBASE && !ctl_q[CB_ENABLE]),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .q_o    (vbase_q)
   );

   // ---------------- trigger and semaphore ----------------
   logic [HALF-1:0] trig_q;
   logic [HALF-1:0] sem_q;

   hrb_mask_reg #(
      .DATA_W(DATA_W),
      .KEEP  ('1),
      .RESET ('0)
   ) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && sel == SEL_TRIG),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .q_o    (trig_q)
   );

   hrb_mask_reg #(
      .DATA_W(DATA_W),
      .KEEP  ('1),
      .RESET ('0)
   ) u_sem (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && sel == SEL_SEM),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .q_o    (sem_q)
   );

   // ---------------- condition code and program counter ----------------
   logic [DATA_W-1:0] ccr_q;
   logic [DATA_W-1:0] pc_q;

   hrb_lane_reg #(
      .DATA_W(DATA_W),
      .IMPL  (CCR_IMPL),
      .RESET ('0)
   ) u_ccr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && sel == SEL_CCR),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .q_o    (ccr_q)
   );

   hrb_lane_reg #(
      .DATA_W(DATA_W),
      .IMPL  ('1),
      .RESET ('0)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr && sel == SEL_PC),
      .be_i   (be_i),
      .wdata_i(wdata_i),
      .q_o    (pc_q)
   );

   // ---------------- general registers ----------------
   logic [DATA_W-1:0] gpr_q [NUM_GPR];

   for (genvar g = 0; g < int'(NUM_GPR); g++) begin : g_gpr
      hrb_lane_reg #(
         .DATA_W(DATA_W),
         .IMPL  ('1),
         .RESET ('0)
      ) u_gpr (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en_i(wr && sel == SEL_GPR && int'(idx) == g),
         .be_i   (be_i),
         .wdata_i(wdata_i),
         .q_o    (gpr_q[g])
      );
   end

   // ---------------- read-only flag bank ----------------
   logic [DATA_W-1:0] flag_q [FLAG_WORDS];

   for (genvar f = 0; f < int'(FLAG_WORDS); f++) begin : g_flag
      if (f == 0) begin : g_first
         assign flag_q[f] = DATA_W'(FLAG0_RESET);
      end else begin : g_rest
         assign flag_q[f] = '0;
      end
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;

   hrb_rd_mux #(
      .DATA_W    (DATA_W),
      .NUM_GPR   (NUM_GPR),
      .FLAG_WORDS(FLAG_WORDS)
   ) u_rd_mux (
      .sel_i  (sel),
      .idx_i  (idx),
      .ctl_i  (ctl_q),
      .vbase_i(vbase_q),
      .trig_i (trig_q),
      .sem_i  (sem_q),
      .ccr_i  (ccr_q),
      .pc_i   (pc_q),
      .gpr_i  (gpr_q),
      .flag_i (flag_q),
      .data_o (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
         ack_o   <= 1'b0;
      end else begin
         ack_o   <= req_i;
         rdata_o <= (req_i && !we_i) ? rd_mux : '0;
      end
   end

   // ---------------- core-side outputs ----------------
   assign core_enable_o = ctl_q[CB_ENABLE];
   assign core_freeze_o = ctl_q[CB_FREEZE];
   assign core_debug_o  = ctl_q[CB_DEBUG];
   assign core_force_o  = ctl_q[CB_FORCE];
   assign core_swerr_o  = ctl_q[CB_SWERR];
   assign core_irqen_o  = ctl_q[CB_IRQEN];
   assign core_step_o   = step_q;
   assign vbase_o       = vbase_q;

endmodule

// File: rtl/hrb_host_regs_chk.sv
module hrb_host_regs_chk
   import hrb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_GPR    = 7,
   parameter int unsigned FLAG_BASE  = 16,
   parameter int unsigned FLAG_WORDS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_i,
   input logic                we_i,
   input logic [ADDR_W-1:0]   adr_i,
   input logic [DATA_W/8-1:0] be_i,
   input logic [DATA_W-1:0]   rdata_o,
   input logic                ack_o,
   input logic                core_enable_o,
   input logic                core_freeze_o,
   input logic                core_debug_o,
   input logic                core_force_o,
   input logic                core_step_o,
   input logic                core_swerr_o,
   input logic                core_irqen_o,
   input logic [DATA_W-1:0]   vbase_o
);

   logic       unmapped;
   logic       ctl_full_wr;
   logic [5:0] ctl_bits;

   assign unmapped = (int'(adr_i) >= int'(OFS_GPR0 + NUM_GPR) && int'(adr_i) < int'(FLAG_BASE)) ||
                     (int'(adr_i) >= int'(FLAG_BASE + FLAG_WORDS));
   assign ctl_full_wr = req_i && we_i && int'(adr_i) == int'(OFS_CTL) && (&be_i);
   assign ctl_bits = {core_enable_o, core_freeze_o, core_debug_o,
                      core_force_o, core_swerr_o, core_irqen_o};

   assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> ack_o);

   assert_ack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !ack_o);

   assert_ctl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_full_wr |=> $stable(ctl_bits));

   assert_step_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      core_step_o |-> $past(ctl_full_wr));

   assert_vbase_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vbase_o[0] == 1'b0);

   assert_vbase_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && we_i && int'(adr_i) == int'(OFS_VBASE) && core_enable_o) |=> $stable(vbase_o));

   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i && unmapped) |=> rdata_o == '0);

endmodule

bind hrb_host_regs hrb_host_regs_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_GPR   (NUM_GPR),
   .FLAG_BASE (FLAG_BASE),
   .FLAG_WORDS(FLAG_WORDS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .we_i         (we_i),
   .adr_i        (adr_i),
   .be_i         (be_i),
   .rdata_o      (rdata_o),
   .ack_o        (ack_o),
   .core_enable_o(core_enable_o),
   .core_freeze_o(core_freeze_o),
   .core_debug_o (core_debug_o),
   .core_force_o (core_force_o),
   .core_step_o  (core_step_o),
   .core_swerr_o (core_swerr_o),
   .core_irqen_o (core_irqen_o),
   .vbase_o      (vbase_o)
);

// File: tb/test_hrb_host_regs.sv
module test_hrb_host_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        we_i = 1'b0;
   logic [4:0]  adr_i = '0;
   logic [1:0]  be_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        ack_o;
   logic        core_enable_o, core_freeze_o, core_debug_o, core_force_o;
   logic        core_step_o, core_swerr_o, core_irqen_o;
   logic [15:0] vbase_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0] mdl [32];

   always #5 clk = ~clk;

   hrb_host_regs i_hrb_host_regs (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .adr_i(adr_i),
      .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o),
      .core_enable_o(core_enable_o), .core_freeze_o(core_freeze_o),
      .core_debug_o(core_debug_o), .core_force_o(core_force_o),
      .core_step_o(core_step_o), .core_swerr_o(core_swerr_o),
      .core_irqen_o(core_irqen_o), .vbase_o(vbase_o)
   );

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(int a);
      if (a == 0) return "R3";
      if (a == 1) return "R5";
      if (a == 2 || a == 3) return "R7";
      if (a == 4) return "R8";
      if (a >= 5 && a <= 12) return "R9";
      if (a >= 16 && a <= 23) return "R10";
      return "R11";
   endfunction

   function automatic void mdl_reset();
      for (int i = 0; i < 32; i++) mdl[i] = 16'h0000;
      mdl[1]  = 16'hFE00;
      mdl[16] = 16'h0001;
   endfunction

   // expected effect of one write, derived from the requirements
   function automatic void mdl_write(int a, logic [1:0] be, logic [15:0] d);
      logic [7:0] keep;
      if (a == 0 || a == 2 || a == 3) begin
         keep = (a == 0) ? 8'hF3 : 8'hFF;
         if (be == 2'b11)
            for (int i = 0; i < 8; i++)
               if (keep[i] && d[i+8]) mdl[a][i] = d[i];
      end else if (a == 1) begin
         if (!mdl[0][7]) begin
            if (be[0]) mdl[1][7:0]  = d[7:0];
            if (be[1]) mdl[1][15:8] = d[15:8];
            mdl[1][0] = 1'b0;
         end
      end else if (a == 4) begin
         if (be[0]) mdl[4] = {12'h000, d[3:0]};
      end else if (a >= 5 && a <= 12) begin
         if (be[0]) mdl[a][7:0]  = d[7:0];
         if (be[1]) mdl[a][15:8] = d[15:8];
      end
   endfunction

   task automatic bus_read(int a, output logic [15:0] d);
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b0; adr_i = 5'(a); be_i = 2'b11;
      @(posedge clk);
      @(negedge clk);
      d = rdata_o;
      chk("R2", {15'h0, ack_o}, 16'h0001);
      req_i = 1'b0;
   endtask

   task automatic bus_write(int a, logic [1:0] be, logic [15:0] d);
      logic exp_step;
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b1; adr_i = 5'(a); be_i = be; wdata_i = d;
      @(posedge clk);
      @(negedge clk);
      req_i = 1'b0; we_i = 1'b0;
      exp_step = (a == 0) && (be == 2'b11) && d[10] && d[2];
      mdl_write(a, be, d);
      chk("R4", {15'h0, core_step_o}, {15'h0, exp_step});
      chk("R12", {10'h0, core_enable_o, core_freeze_o, core_debug_o,
                  core_force_o, core_swerr_o, core_irqen_o},
                 {10'h0, mdl[0][7], mdl[0][6], mdl[0][5], mdl[0][4],
                  mdl[0][1], mdl[0][0]});
      chk("R12", vbase_o, mdl[1]);
      @(negedge clk);
      chk("R4", {15'h0, core_step_o}, 16'h0000);
   endtask

   task automatic rd_chk(int a, string tag);
      logic [15:0] d;
      bus_read(a, d);
      chk(tag, d, mdl[a]);
   endtask

   task automatic rd_lit(int a, string tag, logic [15:0] lit);
      logic [15:0] d;
      bus_read(a, d);
      chk(tag, d, lit);
   endtask

   initial begin
      logic [15:0] d;
      void'($urandom(32'd1234));
      mdl_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset image
      chk("R1", vbase_o, 16'hFE00);
      chk("R1", {15'h0, core_enable_o}, 16'h0000);
      for (int a = 0; a < 32; a++) rd_chk(a, "R1");
      rd_lit(16, "R1", 16'h0001);
      rd_lit(1, "R1", 16'hFE00);

      // R3: masked control writes
      bus_write(0, 2'b11, 16'hD0D0);
      rd_lit(0, "R3", 16'h00D0);
      bus_write(0, 2'b11, 16'h8000);
      rd_lit(0, "R3", 16'h0050);
      bus_write(0, 2'b11, 16'h5000);
      rd_lit(0, "R3", 16'h0000);
      bus_write(0, 2'b10, 16'hFFFF);
      rd_lit(0, "R3", 16'h0000);
      bus_write(0, 2'b01, 16'hFFFF);
      rd_lit(0, "R3", 16'h0000);
      bus_write(0, 2'b11, 16'hFFFF);
      rd_lit(0, "R3", 16'h00F3);
      bus_write(0, 2'b11, 16'h2000);
      rd_lit(0, "R3", 16'h00D3);
      bus_write(0, 2'b11, 16'hFF00);
      rd_lit(0, "R3", 16'h0000);

      // R4: single step pulse
      bus_write(0, 2'b11, 16'h0404);
      rd_lit(0, "R4", 16'h0000);

      // R5 / R6: vector base
      bus_write(1, 2'b11, 16'h5555);
      rd_lit(1, "R5", 16'h5554);
      bus_write(1, 2'b11, 16'hAAAA);
      rd_lit(1, "R5", 16'hAAAA);
      bus_write(1, 2'b01, 16'hFF55);
      rd_lit(1, "R5", 16'hAA54);
      bus_write(1, 2'b10, 16'h55AA);
      rd_lit(1, "R5", 16'h5554);
      bus_write(0, 2'b11, 16'h8080);
      bus_write(1, 2'b11, 16'hFFFF);
      rd_lit(1, "R6", 16'h5554);
      bus_write(1, 2'b01, 16'h00FF);
      rd_lit(1, "R6", 16'h5554);
      bus_write(0, 2'b11, 16'h8000);

      // R7: trigger and semaphore
      for (int a = 2; a <= 3; a++) begin
         bus_write(a, 2'b11, 16'hFFFF);
         rd_lit(a, "R7", 16'h00FF);
         bus_write(a, 2'b01, 16'hFF00);
         rd_lit(a, "R7", 16'h00FF);
         bus_write(a, 2'b10, 16'hFF00);
         rd_lit(a, "R7", 16'h00FF);
         bus_write(a, 2'b11, 16'hFF00);
         rd_lit(a, "R7", 16'h0000);
      end

      // R8: condition code
      bus_write(4, 2'b01, 16'hFFFF);
      rd_lit(4, "R8", 16'h000F);
      bus_write(4, 2'b10, 16'h0000);
      rd_lit(4, "R8", 16'h000F);
      bus_write(4, 2'b11, 16'hFFF0);
      rd_lit(4, "R8", 16'h0000);

      // R9: program counter and general registers
      for (int a = 5; a <= 12; a++) begin
         bus_write(a, 2'b01, 16'hFF33);
         rd_lit(a, "R9", 16'h0033);
         bus_write(a, 2'b10, 16'hCCFF);
         rd_lit(a, "R9", 16'hCC33);
         bus_write(a, 2'b11, 16'(16'h1000 * a + 16'h0F1F));
         rd_chk(a, "R9");
      end

      // R10: flag bank ignores writes
      for (int a = 16; a <= 23; a++) begin
         bus_write(a, 2'b11, 16'hA5A5);
         rd_chk(a, "R10");
      end
      rd_lit(16, "R10", 16'h0001);

      // R11: unmapped offsets
      bus_write(13, 2'b11, 16'hFFFF);
      bus_write(31, 2'b11, 16'hFFFF);
      rd_lit(13, "R11", 16'h0000);
      rd_lit(31, "R11", 16'h0000);
      for (int a = 0; a < 13; a++) rd_chk(a, "R11");

      // random traffic against the model
      for (int n = 0; n < 600; n++) begin
         int a;
         a = int'($urandom_range(0, 31));
         if ($urandom_range(0, 1) == 1)
            bus_write(a, 2'($urandom_range(0, 3)), 16'($urandom));
         else
            rd_chk(a, tag_of(a));
      end

      // closing sweep
      for (int a = 0; a < 32; a++) rd_chk(a, tag_of(a));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule